// File: doc/BRIEF.md
# Bit-field rotate-mask-shift-merge datapath

This block wraps a small arithmetic unit with four fixed-position bit-field stages, so that a variable-length field can be pulled out of a byte, combined with an auxiliary operand and written back into part of a bus byte in a single operation. A source byte is first rotated right and optionally trimmed to its low bits. It then goes through the ALU, which can pass it, add it to the auxiliary operand, AND it with that operand or XOR it with that operand. The ALU result is then optionally shifted left and merged into a held bus buffer. Two routing flags select which stages take part. One flag says whether the source came from the bus. The other says whether the result goes to the bus.

One operation is accepted per clock while `op_valid` is high. A register-bound result lands in `res_q`. A bus-bound result updates the bus buffer `bus_q`. The carry of an add is kept in `ovf_q`. All three outputs are registered and change one clock after the operation is presented. The storage that feeds the source and auxiliary bytes and the decoding of instruction words lie outside this block.

Top module: `bfu_datapath`

## Requirements
- R1: While `rst_n` is low, `res_q`, `bus_q` and `ovf_q` are all zero.
- R2: An operation with `src_bus`=0 and `dst_bus`=0 loads `res_q` with ALU(`aux_data`, `src_data` rotated right by `cnt`), with no masking, and leaves `bus_q` unchanged.
- R3: An operation with `src_bus`=1 and `dst_bus`=0 loads `res_q` with ALU(`aux_data`, M), where M is `src_data` rotated right by `cnt` with every bit at position `fld_len` and above cleared. The same operation loads `bus_q` with the raw `src_data`.
- R4: When the mask stage is active and `fld_len` is 0, no bits are cleared and all 8 bits pass.
- R5: An operation with `src_bus`=0 and `dst_bus`=1 takes the unrotated source through the ALU and shifts the result left by `cnt`, filling with zeros. Buffer bits at positions `cnt` up to `cnt`+`fld_len`-1 (those below 8) take the matching shifted bits. All other buffer bits keep their value, and `res_q` is unchanged.
- R6: When the merge stage is active and `fld_len` is 0, all 8 buffer bits are replaced by the shifted ALU result.
- R7: An operation with `src_bus`=1 and `dst_bus`=1 applies rotate, mask, ALU, shift and merge in that order. The rotate and the shift use the same `cnt`, and the mask and the merge use the same `fld_len`.
- R8: The `alu_op` encoding is 0 pass, 1 add modulo 256, 2 AND and 3 XOR. Each operation other than pass combines `aux_data` with the stage-processed source.
- R9: `ovf_q` takes the carry out of bit 7 on every accepted add. Other operations leave it unchanged.
- R10: While `op_valid` is low, `res_q`, `bus_q` and `ovf_q` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Accept an operation this cycle |
| alu_op | input | 2 | ALU function: 0 pass, 1 add, 2 AND, 3 XOR |
| src_bus | input | 1 | Source byte came from the bus (enables the mask stage) |
| dst_bus | input | 1 | Result goes to the bus buffer (enables shift and merge) |
| cnt | input | 3 | Rotate-right and shift-left count |
| fld_len | input | 3 | Field length for mask and merge; 0 means all 8 bits |
| src_data | input | 8 | Source byte |
| aux_data | input | 8 | Auxiliary operand |
| res_q | output | 8 | Register-bound result |
| bus_q | output | 8 | Bus buffer, the last byte moved to or from the bus |
| ovf_q | output | 1 | Carry captured from the last add |

## Verification
The assertions assume that `op_valid` and both routing flags are known at every rising edge after reset. They also assume that `src_data` is stable across the edge on which a bus-to-register operation is captured. The bench changes every input only on falling edges, so it meets both assumptions. It sweeps every combination of ALU function, routing, count and length twice with fresh data. It also places idle cycles with random data on the other inputs between operations.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_AND  = 2'd2,
      ALU_XOR  = 2'd3
   } alu_op_e;
endpackage

// File: rtl/bfu_rotmask.sv
module bfu_rotmask #(
   parameter int W     = 8,
   parameter int CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     din,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] len,
   input  logic             rot_en,
   input  logic             mask_en,
   output logic [W-1:0]     dout
);
   logic [W-1:0] stage [0:CNT_W];
   logic [W-1:0] keep;

   assign stage[0] = din;

   // logarithmic right rotator, one stage per count bit
   for (genvar g = 0; g < CNT_W; g++) begin : g_rot
      localparam int AMT = 1 << g;
      assign stage[g+1] = (rot_en && cnt[g])
                        ? {stage[g][AMT-1:0], stage[g][W-1:AMT]}
                        : stage[g];
   end

   // low-bit keep mask; zero length keeps everything
   for (genvar i = 0; i < W; i++) begin : g_keep
      assign keep[i] = !mask_en || (len == '0) || (CNT_W'(i) < len);
   end

   assign dout = stage[CNT_W] & keep;
endmodule

// File: rtl/bfu_alu.sv
module bfu_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0]        a,
   input  logic [W-1:0]        b,
   input  bfu_pkg::alu_op_e    op,
   output logic [W-1:0]        y,
   output logic                carry
);
   import bfu_pkg::*;
   logic [W:0] sum;

   assign sum   = {1'b0, a} + {1'b0, b};
   assign carry = sum[W];

   always_comb begin
      unique case (op)
         ALU_PASS: y = b;
         ALU_ADD:  y = sum[W-1:0];
         ALU_AND:  y = a & b;
         ALU_XOR:  y = a ^ b;
         default:  y = b;
      endcase
   end
endmodule

// File: rtl/bfu_shiftmerge.sv
module bfu_shiftmerge #(
   parameter int W     = 8,
   parameter int CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     din,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] len,
   input  logic [W-1:0]     buf_in,
   output logic [W-1:0]     dout
);
   logic [W-1:0] stage [0:CNT_W];
   logic [W-1:0] field;
   logic [CNT_W:0] cnt_x;
   logic [CNT_W:0] top_x;

   assign stage[0] = din;
   assign cnt_x    = {1'b0, cnt};
   assign top_x    = cnt_x + {1'b0, len};

   // logarithmic left shifter, zero fill
   for (genvar g = 0; g < CNT_W; g++) begin : g_shl
      localparam int AMT = 1 << g;
      assign stage[g+1] = cnt[g]
                        ? {stage[g][W-AMT-1:0], {AMT{1'b0}}}
                        : stage[g];
   end

   // field of buffer bits that get replaced
   for (genvar i = 0; i < W; i++) begin : g_fld
      localparam logic [CNT_W:0] POS = (CNT_W+1)'(i);
      assign field[i] = (len == '0) || ((POS >= cnt_x) && (POS < top_x));
   end

   assign dout = (buf_in & ~field) | (stage[CNT_W] & field);
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath #(
   parameter int W     = 8,
   parameter int CNT_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       alu_op,
   input  logic             src_bus,
   input  logic             dst_bus,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] fld_len,
   input  logic [W-1:0]     src_data,
   input  logic [W-1:0]     aux_data,
   output logic [W-1:0]     res_q,
   output logic [W-1:0]     bus_q,
   output logic             ovf_q
);
   import bfu_pkg::*;

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("bfu_datapath: W must be a power of two, at least 2");
   end
   if (CNT_W != $clog2(W)) begin : g_bad_cnt
      $error("bfu_datapath: CNT_W must equal clog2(W)");
   end

   logic            rot_en;
   logic [W-1:0]    pre_alu;
   logic [W-1:0]    alu_y;
   logic            alu_c;
   logic [W-1:0]    merged;
   alu_op_e         op_e;

   // rotation is skipped only on register-to-bus transfers
   assign rot_en = src_bus || !dst_bus;
   assign op_e   = alu_op_e'(alu_op);

   bfu_rotmask #(.W(W), .CNT_W(CNT_W)) u_front (
      .din     (src_data),
      .cnt     (cnt),
      .len     (fld_len),
      .rot_en  (rot_en),
      .mask_en (src_bus),
      .dout    (pre_alu)
   );

   bfu_alu #(.W(W)) u_alu (
      .a     (aux_data),
      .b     (pre_alu),
      .op    (op_e),
      .y     (alu_y),
      .carry (alu_c)
   );

   bfu_shiftmerge #(.W(W), .CNT_W(CNT_W)) u_back (
      .din    (alu_y),
      .cnt    (cnt),
      .len    (fld_len),
      .buf_in (bus_q),
      .dout   (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
         bus_q <= '0;
         ovf_q <= 1'b0;
      end else if (op_valid) begin
         if (dst_bus) begin
            bus_q <= merged;
         end else begin
            res_q <= alu_y;
            if (src_bus) bus_q <= src_data;
         end
         if (op_e == ALU_ADD) ovf_q <= alu_c;
      end
   end
endmodule

// File: rtl/bfu_datapath_chk.sv
module bfu_datapath_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [1:0]   alu_op,
   input logic         src_bus,
   input logic         dst_bus,
   input logic [W-1:0] src_data,
   input logic [W-1:0] res_q,
   input logic [W-1:0] bus_q,
   input logic         ovf_q
);
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(res_q) && $stable(bus_q) && $stable(ovf_q)));

   // R2
   reg_reg_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !src_bus && !dst_bus) |=> $stable(bus_q));

   // R3
   bus_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && src_bus && !dst_bus) |=> (bus_q == $past(src_data)));

   // R5
   bus_out_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dst_bus) |=> $stable(res_q));

   // R9
   no_add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && alu_op != 2'd1) |=> $stable(ovf_q));
endmodule

bind bfu_datapath bfu_datapath_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .alu_op   (alu_op),
   .src_bus  (src_bus),
   .dst_bus  (dst_bus),
   .src_data (src_data),
   .res_q    (res_q),
   .bus_q    (bus_q),
   .ovf_q    (ovf_q)
);

// File: tb/bfu_datapath_bench.sv
module bfu_datapath_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [1:0] alu_op = '0;
   logic       src_bus = 1'b0;
   logic       dst_bus = 1'b0;
   logic [2:0] cnt = '0;
   logic [2:0] fld_len = '0;
   logic [7:0] src_data = '0;
   logic [7:0] aux_data = '0;
   logic [7:0] res_q;
   logic [7:0] bus_q;
   logic       ovf_q;

   int checks = 0;
   int errors = 0;
   int m_res = 0;
   int m_bus = 0;
   int m_ovf = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfu_datapath u_bfu_datapath (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .alu_op(alu_op),
      .src_bus(src_bus), .dst_bus(dst_bus), .cnt(cnt), .fld_len(fld_len),
      .src_data(src_data), .aux_data(aux_data),
      .res_q(res_q), .bus_q(bus_q), .ovf_q(ovf_q)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all(string t_res, string t_bus, string t_ovf);
      chk(t_res, int'(res_q), m_res);
      chk(t_bus, int'(bus_q), m_bus);
      chk(t_ovf, int'(ovf_q), m_ovf);
   endtask

   // behavioural reference of one accepted operation
   task automatic model_op(int op, bit sb, bit db, int c, int l, int s, int a);
      int v, r, sum, sh, fm;
      v = s;
      if (sb || !db) v = ((v >> c) | (v << (8 - c))) & 255;
      if (sb && l != 0) v = v & ((1 << l) - 1);
      sum = a + v;
      case (op)
         0: r = v;
         1: r = sum & 255;
         2: r = a & v;
         default: r = a ^ v;
      endcase
      if (db) begin
         sh = (r << c) & 255;
         fm = (l == 0) ? 255 : ((((1 << l) - 1) << c) & 255);
         m_bus = (m_bus & ~fm & 255) | (sh & fm);
      end else begin
         m_res = r;
         if (sb) m_bus = s;
      end
      if (op == 1) m_ovf = sum >> 8;
   endtask

   task automatic run_op(bit v, int op, bit sb, bit db, int c, int l, int s, int a);
      string tr, tb;
      op_valid = v; alu_op = 2'(op); src_bus = sb; dst_bus = db;
      cnt = 3'(c); fld_len = 3'(l); src_data = 8'(s); aux_data = 8'(a);
      if (v) model_op(op, sb, db, c, l, s, a);
      @(negedge clk);
      if (!v) begin
         compare_all("R10 res", "R10 bus", "R10 ovf");
      end else begin
         case ({sb, db})
            2'b00: begin tr = "R2/R8 res"; tb = "R2 bus"; end
            2'b10: begin tr = (l == 0) ? "R4/R8 res" : "R3/R8 res"; tb = "R3 bus"; end
            2'b01: begin tr = "R5 res"; tb = (l == 0) ? "R6 bus" : "R5/R8 bus"; end
            default: begin tr = "R7 res"; tb = (l == 0) ? "R6/R7 bus" : "R7 bus"; end
         endcase
         compare_all(tr, tb, "R9 ovf");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      compare_all("R1 res", "R1 bus", "R1 ovf");
      rst_n = 1'b1;
      run_op(1'b0, 1, 1'b1, 1'b1, 5, 3, 8'hA5, 8'h5A);
      // directed: add with carry, then pass holds carry (R9)
      run_op(1'b1, 1, 1'b0, 1'b0, 0, 0, 8'hF0, 8'h20);
      run_op(1'b1, 0, 1'b0, 1'b0, 3, 0, 8'h81, 8'h00);
      // directed: bus input with zero length keeps all bits (R4)
      run_op(1'b1, 0, 1'b1, 1'b0, 1, 0, 8'hC3, 8'h00);
      // directed: merge zero length replaces buffer (R6)
      run_op(1'b1, 0, 1'b0, 1'b1, 2, 0, 8'hFF, 8'h00);
      for (int pass = 0; pass < 2; pass++) begin
         for (int op = 0; op < 4; op++) begin
            for (int rt = 0; rt < 4; rt++) begin
               for (int c = 0; c < 8; c++) begin
                  for (int l = 0; l < 8; l++) begin
                     run_op(1'b1, op, rt[1], rt[0], c, l,
                            int'($urandom_range(255)), int'($urandom_range(255)));
                     if (((c + l) % 7) == 3)
                        run_op(1'b0, int'($urandom_range(3)), 1'b1, 1'b1,
                               int'($urandom_range(7)), int'($urandom_range(7)),
                               int'($urandom_range(255)), int'($urandom_range(255)));
                  end
               end
            end
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule